// File: doc/BRIEF.md
# Magnitude Threshold Comparator with Persistence Counter

This block watches a stream of signed current-measurement results. Each result that arrives with its valid strobe is turned into a magnitude and compared against a programmable unsigned threshold. Depending on a 2-bit mode, a result at or above the threshold raises a sticky interrupt at once. Alternatively, the interrupt waits until a persistence counter, advanced by such results, reaches a programmable limit.

The two persistence modes differ in how a result below the threshold acts on the counter. One mode drops the count straight to zero, so only an unbroken run of large results can fire. The other mode takes one step back per small result, so a noisy signal that is mostly above the threshold still reaches the limit. The count is visible on an output so software can watch the state of the filter. The interrupt stays high until a write-one-to-clear pulse removes it.

Top module: `mag_thresh_cmp`

## Requirements
- R1: After reset, `irq` is 0 and `count` is 0.
- R2: The magnitude of `sample` (two's complement, DW bits) is its absolute value, except that the most negative code maps to 2^(DW-1)-1. A result counts as a hit when this magnitude, read as unsigned, is greater than or equal to `threshold`.
- R3: With `mode` = 2'b00 no result raises `irq`, and `count` stays 0.
- R4: With `mode` = 2'b01 every valid hit sets `irq` on the following clock edge, and `count` stays 0.
- R5: With `mode` = 2'b10 a valid hit raises `count` by one, saturating at `limit`, and a valid miss sets `count` to 0. `irq` is set on the edge at which a hit leaves `count` equal to `limit`; with `limit` = 0 every hit sets it.
- R6: With `mode` = 2'b11, hits behave as in R5, but a valid miss lowers `count` by one and never below 0.
- R7: On cycles with `sample_vld` low, neither `count` nor `irq` is changed by `sample`.
- R8: `irq` holds its value until `irq_clr` is high at a clock edge, which clears it. If an interrupt event happens on that same edge, `irq` stays 1.
- R9: On a cycle where `mode` differs from its value on the previous cycle, `count` is set to 0 and that cycle's result is neither counted nor able to set `irq`.
- R10: `count` and `irq` are registered, and change on the clock edge that samples the inputs causing the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 00 off, 01 immediate, 10 persist/clear, 11 persist/step-down |
| threshold | input | DW | Unsigned magnitude threshold |
| limit | input | CW | Persistence limit in conversions |
| sample | input | DW | Signed conversion result |
| sample_vld | input | 1 | Result-valid strobe |
| irq_clr | input | 1 | Write-one-to-clear for the interrupt |
| irq | output | 1 | Sticky interrupt flag |
| count | output | CW | Current persistence count |

## Verification
The two functions that can meet on one edge are the interrupt clear and a new interrupt event. The immediate-mode sweep provokes this meeting deliberately for every sample and threshold pair of a 6-bit configuration, with `irq_clr` high on every sample. The flag after that edge must then equal the hit decision exactly, computed in the bench from the magnitude rule. The random persistence runs also assert the clear at random and judge each edge against an arithmetic model of count and flag. In these runs the clear meets hits, misses, saturation at the limit and mode changes.

// File: rtl/mag_thresh_cmp.sv
module mag_thresh_cmp #(
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic [DW-1:0] threshold,
  input  logic [CW-1:0] limit,
  input  logic [DW-1:0] sample,
  input  logic          sample_vld,
  input  logic          irq_clr,
  output logic          irq,
  output logic [CW-1:0] count
);
  localparam logic [DW-1:0] MAX_MAG = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] MIN_NEG = {1'b1, {(DW-1){1'b0}}};
  localparam logic [1:0] M_OFF = 2'b00, M_IMM = 2'b01, M_CLR = 2'b10, M_DEC = 2'b11;

  logic [1:0]    mode_q;
  logic [DW-1:0] mag;
  logic          hit, mode_chg, event_now;
  logic [CW-1:0] cnt_up, cnt_dn, count_nx;

  assign mag      = (sample == MIN_NEG) ? MAX_MAG :
                    sample[DW-1] ? (~sample + DW'(1)) : sample;
  assign hit      = mag >= threshold;
  assign mode_chg = mode != mode_q;
  assign cnt_up   = (count >= limit) ? limit : count + CW'(1);
  assign cnt_dn   = (count == '0) ? '0 : count - CW'(1);

  always_comb begin
    count_nx  = count;
    event_now = 1'b0;
    if (mode_chg) begin
      count_nx = '0;
    end else if (sample_vld) begin
      unique case (mode)
        M_OFF: count_nx = '0;
        M_IMM: event_now = hit;
        M_CLR, M_DEC: begin
          if (hit) begin
            count_nx  = cnt_up;
            event_now = (cnt_up == limit);
          end else begin
            count_nx = (mode == M_DEC) ? cnt_dn : '0;
          end
        end
        default: count_nx = count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
      count  <= '0;
      irq    <= 1'b0;
    end else begin
      mode_q <= mode;
      count  <= count_nx;
      irq    <= (irq & ~irq_clr) | event_now;
    end
  end
endmodule

// File: rtl/mag_thresh_cmp_chk.sv
module mag_thresh_cmp_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic [CW-1:0] limit,
  input logic          sample_vld,
  input logic          irq_clr,
  input logic          irq,
  input logic [CW-1:0] count
);
  // R3
  a_r3_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (count == '0));
  // R4
  a_r4_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> (count == '0));
  // R5
  a_r5_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (count <= limit) |=> (count <= $past(limit)));
  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld && mode == $past(mode)) |=> $stable(count));
  // R8
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !sample_vld) |=> !irq);
endmodule

bind mag_thresh_cmp mag_thresh_cmp_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .limit(limit),
  .sample_vld(sample_vld), .irq_clr(irq_clr), .irq(irq), .count(count)
);

// File: tb/tb_mag_thresh_cmp.sv
module tb_mag_thresh_cmp;
  localparam int DW = 6;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [DW-1:0] threshold = '0;
  logic [CW-1:0] limit = '0;
  logic [DW-1:0] sample = '0;
  logic          sample_vld = 1'b0;
  logic          irq_clr = 1'b0;
  logic          irq;
  logic [CW-1:0] count;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [1:0]    m_mode = 2'b00;
  logic [CW-1:0] m_cnt = '0;
  logic          m_irq = 1'b0;

  always #2 clk = ~clk;

  mag_thresh_cmp #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .threshold(threshold), .limit(limit),
    .sample(sample), .sample_vld(sample_vld), .irq_clr(irq_clr),
    .irq(irq), .count(count)
  );

  function automatic int magnitude(input logic [DW-1:0] s);
    int v = $signed(s);
    if (v == -(1 << (DW-1))) return (1 << (DW-1)) - 1;
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(input logic [1:0] md, input logic [DW-1:0] s, input logic v,
                       input logic c, input string req);
    bit hit, evt;
    int nc, lim;
    mode = md; sample = s; sample_vld = v; irq_clr = c;
    hit = magnitude(s) >= int'(threshold);
    lim = int'(limit);
    nc = int'(m_cnt);
    evt = 0;
    if (md != m_mode) nc = 0;
    else if (v) begin
      case (md)
        2'b00: nc = 0;
        2'b01: evt = hit;
        default: begin
          if (hit) begin
            nc = (nc >= lim) ? lim : nc + 1;
            evt = (nc == lim);
          end else nc = (md == 2'b11 && nc > 0) ? nc - 1 : 0;
        end
      endcase
    end
    m_cnt = CW'(nc);
    m_irq = (m_irq & ~c) | evt;
    m_mode = md;
    @(posedge clk); #1;
    check(req, "count", int'(count), int'(m_cnt));
    check(req, "irq", int'(irq), int'(m_irq));
  endtask

  task automatic random_run(input logic [1:0] md, input string req, input int n);
    for (int i = 0; i < n; i++) begin
      logic v;
      if (i % 150 == 0) limit = CW'($urandom % 16);
      v = ($urandom % 10) < 7;
      cycle(md, DW'($urandom), v, ($urandom % 10) == 0, v ? req : "R7");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq after reset", int'(irq), 0);
    check("R1", "count after reset", int'(count), 0);
    rst_n = 1'b1;

    // R2/R4/R8: exhaustive sample x threshold sweep, clear on every edge
    cycle(2'b01, '0, 1'b0, 1'b1, "R9");
    for (int t = 0; t < (1 << DW); t++) begin
      threshold = DW'(t);
      for (int s = 0; s < (1 << DW); s++)
        cycle(2'b01, DW'(s), 1'b1, 1'b1, "R2");
    end

    // R8: sticky hold and clear
    threshold = DW'(0);
    cycle(2'b01, DW'(5), 1'b1, 1'b0, "R4");
    cycle(2'b01, DW'(5), 1'b0, 1'b0, "R8");
    cycle(2'b01, DW'(5), 1'b0, 1'b1, "R8");

    threshold = DW'(20);
    random_run(2'b00, "R3", 1000);
    random_run(2'b10, "R5", 3000);
    random_run(2'b11, "R6", 3000);

    // R9: build a count, then change mode with a hit present
    limit = CW'(12);
    for (int i = 0; i < 5; i++) cycle(2'b10, DW'(30), 1'b1, 1'b0, "R5");
    cycle(2'b11, DW'(30), 1'b1, 1'b0, "R9");
    for (int i = 0; i < 3; i++) cycle(2'b11, DW'(30), 1'b1, 1'b0, "R6");
    cycle(2'b11, DW'(2), 1'b1, 1'b0, "R6");
    limit = CW'(0);
    cycle(2'b10, DW'(30), 1'b1, 1'b1, "R9");
    cycle(2'b10, DW'(30), 1'b1, 1'b1, "R5");
    cycle(2'b10, DW'(30), 1'b0, 1'b0, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule